// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the latched event flags of a two-timer counter subsystem. The counter and comparator logic sits outside the block and sends strobes for the events it sees: compare matches on three channels of the main timer and on one channel of the second timer, main-timer overflow, a pin capture event and counter-at-TOP. The block turns each strobe into a sticky flag bit. Software can read the flags over a byte-wide port. Each flag, gated by its own enable, drives one interrupt request line.

Compare flags follow the main timer's tick enable. A match seen on one tick becomes a flag on the next tick. A forced-compare strobe on the same channel blocks that match. The capture flag takes its set source from the waveform mode: it uses the capture pin in most modes, and the counter-at-TOP strobe when the capture register holds TOP. A flag is cleared by writing one to its bit or by pulsing its acknowledge input. A set event in the same cycle as a clear takes priority, so no event is lost.

Top module: `tifr_top`

## Requirements
- R1: After reset all six flags, all interrupt lines and the whole read byte are zero.
- R2: A compare strobe sampled on a cycle with `tick` high sets its flag at the next cycle with `tick` high. The flag is visible one clock after that edge, and cycles with `tick` low in between only delay it. Flag bit positions: bit 4 main-timer channel A (`t3_match[0]`), bit 3 channel B (`t3_match[1]`), bit 1 channel C (`t3_match[2]`), bit 0 second-timer channel C (`t1_match_c`).
- R3: A compare strobe that arrives together with the forced-compare strobe of its channel never sets that channel's flag.
- R4: The capture flag (bit 5) sets from `t3_cap_pin` in any cycle when `wave_mode` is not 8, 10, 12 or 14. In those four modes it sets only from `t3_at_top` in a cycle with `tick` high, and the pin has no effect.
- R5: The overflow flag (bit 2) sets when `t3_ovf` is high in a cycle with `tick` high. Without `tick` the strobe is ignored.
- R6: A cycle with `wr_en` high clears every flag whose `wr_data` bit is one. Flags whose `wr_data` bit is zero are left unchanged.
- R7: A high bit in `ack` clears the flag at the same bit position.
- R8: If a flag's set event and its clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R9: Read bits 7:6 always read as zero. Writes to those bits change no flag.
- R10: `irq[i]` equals flag i AND `irq_en[i]`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Main timer clock enable |
| t3_match | input | 3 | Main-timer compare strobes, channels A, B, C |
| t1_match_c | input | 1 | Second-timer channel C compare strobe |
| t3_force | input | 3 | Main-timer forced-compare strobes, channels A, B, C |
| t1_force_c | input | 1 | Second-timer channel C forced-compare strobe |
| t3_ovf | input | 1 | Main-timer overflow strobe |
| t3_cap_pin | input | 1 | Capture event from the input pin |
| t3_at_top | input | 1 | Main counter has reached TOP |
| wave_mode | input | 4 | Waveform mode selection |
| ack | input | 6 | Per-flag interrupt acknowledge pulses |
| irq_en | input | 6 | Per-flag interrupt enables |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_data | output | 8 | Register read value |
| flags | output | 6 | Flag bits |
| irq | output | 6 | Interrupt request lines |

## Verification
Compare strobes are applied with `tick` high on every cycle and again with `tick` held low for two cycles after the match. The first shows the one-tick delay, and the second shows that the delay is counted in ticks, not clocks. A match combined with a force strobe separates a blocked compare from a delayed one. The capture input is driven from the pin and from the TOP strobe under both a pin mode and a TOP mode, which shows that the source follows the mode. Clears are tried as write-zero, write-one, acknowledge, and clears that collide with set events, which shows the priority between set and clear.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
  localparam int FLAG_W = 6;
  localparam int REG_W  = 8;
  localparam int MODE_W = 4;
  localparam int N_CMP  = 4;

  // flag bit positions in the register byte
  localparam int B_T1C = 0;
  localparam int B_T3C = 1;
  localparam int B_OVF = 2;
  localparam int B_T3B = 3;
  localparam int B_T3A = 4;
  localparam int B_CAP = 5;

  // compare channel index to flag bit position
  function automatic int cmp_bit(input int idx);
    case (idx)
      0:       return B_T3A;
      1:       return B_T3B;
      2:       return B_T3C;
      default: return B_T1C;
    endcase
  endfunction

  // modes in which the capture register serves as TOP
  function automatic logic cap_is_top(input logic [MODE_W-1:0] m);
    return m[MODE_W-1] & ~m[0];
  endfunction
endpackage

// File: rtl/tifr_cmp_stage.sv
module tifr_cmp_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  input  logic force_i,
  output logic set_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (tick_i) pend_d = match_i & ~force_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign set_o = tick_i & pend_q;

  AST_FORCE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && force_i |=> !pend_q); // R3
  AST_MATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && match_i && !force_i |=> pend_q); // R2
  AST_WAIT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pend_q)); // R2
endmodule

// File: rtl/tifr_src_sel.sv
module tifr_src_sel
  import tifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cap_pin_i,
  input  logic              at_top_i,
  input  logic              ovf_i,
  output logic              cap_set_o,
  output logic              ovf_set_o
);
  logic top_mode;

  always_comb begin
    top_mode  = cap_is_top(mode_i);
    cap_set_o = top_mode ? (tick_i & at_top_i) : cap_pin_i;
    ovf_set_o = tick_i & ovf_i;
  end

  AST_CAP_TOP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd12) && !at_top_i |-> !cap_set_o); // R4
  AST_CAP_PIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd0) && cap_pin_i |-> cap_set_o); // R4
  AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !ovf_set_o); // R5
endmodule

// File: rtl/tifr_flag_bit.sv
module tifr_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !q_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && !clr_i |=> $stable(q_o)); // R6
endmodule

// File: rtl/tifr_top.sv
module tifr_top
  import tifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        t3_match,
  input  logic              t1_match_c,
  input  logic [2:0]        t3_force,
  input  logic              t1_force_c,
  input  logic              t3_ovf,
  input  logic              t3_cap_pin,
  input  logic              t3_at_top,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic [FLAG_W-1:0] ack,
  input  logic [FLAG_W-1:0] irq_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] irq
);
  localparam int RSV_W = REG_W - FLAG_W;

  logic [N_CMP-1:0]  cmp_match, cmp_force, cmp_set;
  logic [FLAG_W-1:0] set_vec, clr_vec;
  logic              cap_set, ovf_set;

  assign cmp_match = {t1_match_c, t3_match};
  assign cmp_force = {t1_force_c, t3_force};

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    tifr_cmp_stage u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .match_i (cmp_match[c]),
      .force_i (cmp_force[c]),
      .set_o   (cmp_set[c])
    );
  end

  tifr_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .mode_i    (wave_mode),
    .cap_pin_i (t3_cap_pin),
    .at_top_i  (t3_at_top),
    .ovf_i     (t3_ovf),
    .cap_set_o (cap_set),
    .ovf_set_o (ovf_set)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_CAP] = cap_set;
    set_vec[B_OVF] = ovf_set;
    for (int c = 0; c < N_CMP; c++) set_vec[cmp_bit(c)] = cmp_set[c];
    clr_vec = ack | ({FLAG_W{wr_en}} & wr_data[FLAG_W-1:0]);
  end

  for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
    tifr_flag_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[f]),
      .clr_i (clr_vec[f]),
      .q_o   (flags[f])
    );
  end

  assign irq     = flags & irq_en;
  assign rd_data = {{RSV_W{1'b0}}, flags};

  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (|wr_data[REG_W-1:FLAG_W]) && !(|wr_data[FLAG_W-1:0]) && !(|ack) && !(|set_vec)
    |=> $stable(flags)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags) |-> !(|irq)); // R10
endmodule

// File: tb/tifr_top_bench.sv
module tifr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [2:0] t3_match, t3_force;
  logic       t1_match_c, t1_force_c, t3_ovf, t3_cap_pin, t3_at_top;
  logic [3:0] wave_mode;
  logic [5:0] ack, irq_en;
  logic       wr_en;
  logic [7:0] wr_data, rd_data;
  logic [5:0] flags, irq;

  typedef struct {
    logic [5:0] ef;
    logic [5:0] eirq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #10 clk = ~clk;

  tifr_top u_tifr_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .t3_match(t3_match), .t1_match_c(t1_match_c),
    .t3_force(t3_force), .t1_force_c(t1_force_c), .t3_ovf(t3_ovf), .t3_cap_pin(t3_cap_pin),
    .t3_at_top(t3_at_top), .wave_mode(wave_mode), .ack(ack), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .flags(flags), .irq(irq)
  );

  // monitor: compares at the falling edge, before the driver touches inputs
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (flags !== e.ef || irq !== e.eirq || rd_data !== {2'b00, e.ef}) begin
        n_bad++;
        $display("FAIL %s: flags=%h irq=%h rd=%h expected flags=%h irq=%h rd=%h",
                 e.tag, flags, irq, rd_data, e.ef, e.eirq, {2'b00, e.ef});
      end
    end
  end

  task automatic idle_inputs();
    t3_match = '0; t1_match_c = 0; t3_force = '0; t1_force_c = 0;
    t3_ovf = 0; t3_cap_pin = 0; t3_at_top = 0; ack = '0; wr_en = 0; wr_data = '0;
  endtask

  // driver: one clock with current inputs, then queue the expected result
  task automatic step(input logic [5:0] ef, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.ef = ef; e.eirq = ef & irq_en; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    #2;
    idle_inputs();
  endtask

  task automatic wr(input logic [7:0] d, input logic [5:0] ef, input string tag);
    wr_en = 1; wr_data = d;
    step(ef, tag);
  endtask

  initial begin
    rst_n = 0; tick = 1; wave_mode = 4'd0; irq_en = 6'h3F;
    idle_inputs();
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    step(6'h00, "R1 reset state");

    t3_match[0] = 1; step(6'h00, "R2 no flag on match tick");
    step(6'h10, "R2 channel A flag one tick later");
    wr(8'h00, 6'h10, "R6 write zero keeps");
    wr(8'hEF, 6'h10, "R6 write other bits keeps");
    wr(8'h10, 6'h00, "R6 write one clears");

    t3_match[1] = 1; t3_force[1] = 1; step(6'h00, "R3 forced match");
    step(6'h00, "R3 no flag after forced match");

    t3_match[2] = 1; step(6'h00, "R2 channel C armed");
    tick = 0; step(6'h00, "R2 waits for tick 1");
    step(6'h00, "R2 waits for tick 2");
    tick = 1; step(6'h02, "R2 channel C on next tick");
    t1_match_c = 1; step(6'h02, "R2 second timer armed");
    step(6'h03, "R2 second timer flag");
    ack[1] = 1; step(6'h01, "R7 ack clears bit1");
    ack[0] = 1; step(6'h00, "R7 ack clears bit0");

    tick = 0; t3_ovf = 1; step(6'h00, "R5 overflow without tick");
    tick = 1; t3_ovf = 1; step(6'h04, "R5 overflow sets");
    t3_ovf = 1; wr_en = 1; wr_data = 8'h04; step(6'h04, "R8 set beats write clear");
    t3_ovf = 1; ack[2] = 1; step(6'h04, "R8 set beats ack");
    wr(8'h04, 6'h00, "R6 clear overflow");

    wave_mode = 4'd0; t3_cap_pin = 1; step(6'h20, "R4 pin capture in mode 0");
    wr(8'hC0, 6'h20, "R9 reserved write ignored");
    wr(8'h20, 6'h00, "R6 clear capture");
    t3_at_top = 1; step(6'h00, "R4 top ignored in mode 0");
    wave_mode = 4'd12; t3_cap_pin = 1; step(6'h00, "R4 pin ignored in mode 12");
    t3_at_top = 1; step(6'h20, "R4 top sets in mode 12");
    ack[5] = 1; step(6'h00, "R7 ack clears capture");
    wave_mode = 4'd14; tick = 0; t3_at_top = 1; step(6'h00, "R4 top needs tick");
    tick = 1; wave_mode = 4'd0;

    t3_match[0] = 1; step(6'h00, "R2 arm A");
    irq_en = 6'h01; step(6'h10, "R10 irq masked");
    irq_en = 6'h10; step(6'h10, "R10 irq enabled");
    irq_en = 6'h3F; wr(8'h10, 6'h00, "R6 final clear");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule